// File: doc/BRIEF.md
# Disk Command Issue Sequencer

This block sits on the host side of a disk attachment and replaces the software loop that hands a command to it. A request carries an attention type, a 3-bit device number, a command code, an 8-bit options field, a flag that picks a two-word or four-word command, a flag that skips the busy wait, and a flag that says whether command words follow the attention at all. The sequencer then drives a small synchronous register port. It turns interrupts off, waits for the attachment to go idle, raises the attention, turns interrupts back on, and finally streams the command words into the command register. Before it writes the next word it waits for the attachment to take the current one.

Every status poll is limited to a fixed number of reads, with a configurable idle gap between reads. When a request ends, a single-cycle done pulse carries a 2-bit result: success, busy timeout or command timeout. Device number 7 addresses the attachment controller itself, for example for a controller reset. Requests that acknowledge a reset-completed event set the skip flag, because the attachment stays busy during that exchange.

Top module: `dcs_issue_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken only when `req_valid` and `req_ready` are both high. A `req_valid` seen while a request is in progress has no effect on register traffic or results.
- R2: In the cycle after a request is accepted, the sequencer writes 0 to the control register (address 0), which turns interrupts off.
- R3: If `req_skip_busy` is clear, the sequencer reads the status register (address 1) and tests bit 0 (busy). While busy is set, it reads again after `POLL_GAP` idle cycles, until busy reads clear. If `req_skip_busy` is set, no busy read is made.
- R4: If `MAX_TRIES` busy reads in a row all return busy, the request ends with result 1 (busy timeout). The attention register and the command register are never written in that case.
- R5: The attention write goes to address 2 with data `{8'h00, dev[2:0], attn[4:0]}`, which is the attention type ORed with the device number shifted left by 5. This holds for every device number 0..7. The next cycle writes 16'h0001 (interrupt enable) to the control register.
- R6: If `req_with_cmd` is clear, the request ends with result 0 right after the interrupt-enable write.
- R7: Command word 0 is built as `{opts[7:0], dev[2:0], cmd[4:0]}`, with bit 14 forced to 1 when `req_four_words` is set.
- R8: Command words go to address 3 in this order: word 0, then `req_args[15:0]`, then (four-word commands only) `req_args[31:16]` and `req_args[47:32]`. After each word the sequencer reads status bit 1 (command register full), with `POLL_GAP` idle cycles between reads, until it reads clear.
- R9: If `MAX_TRIES` full-flag reads in a row after one word all return full, the request ends with result 2 (command timeout), and no later word is written.
- R10: `done` is high for exactly one cycle per accepted request, `done_code` holds 0, 1 or 2 while `done` is high, and `req_ready` is high in the following cycle.
- R11: Read data is taken exactly one cycle after the read strobe. A read and a write are never issued in the same cycle, and two reads are never issued in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, able to take a request |
| req_attn | input | 5 | Attention type |
| req_dev | input | 3 | Device number (7 = controller) |
| req_cmd | input | 5 | Command code |
| req_opts | input | 8 | Options field for word 0 bits 15:8 |
| req_four_words | input | 1 | 1: four-word command, 0: two-word |
| req_skip_busy | input | 1 | Skip the busy poll |
| req_with_cmd | input | 1 | Send command words after the attention |
| req_args | input | 48 | Command words 1..3, word 1 in bits 15:0 |
| reg_addr | output | 2 | Register select: 0 control, 1 status, 2 attention, 3 command |
| reg_we | output | 1 | Write strobe |
| reg_re | output | 1 | Read strobe |
| reg_wdata | output | 16 | Write data (byte registers use bits 7:0) |
| reg_rdata | input | 2 | Status bits returned one cycle after `reg_re`: bit 0 busy, bit 1 full |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 2 | 0 ok, 1 busy timeout, 2 command timeout |

## Verification
The bench sweeps all eight device numbers and both command lengths. It uses a register responder that holds busy for 0, 1, `MAX_TRIES`-1 or `MAX_TRIES` reads. A design that is off by one in its try counter either times out when busy clears on the last allowed read, or writes the attention after the limit. The full flag is swept the same way per word. If the design stops pacing on it, or writes the next word after a timeout, the logged write sequence and the status-read count no longer match.

Some requests set the skip flag while busy is held. A design that still polls shows extra reads, and at `MAX_TRIES` a false busy timeout. A second request pushed in mid-run would show up as extra writes or a second done pulse. The device-7 controller attention checks that the top device bits reach the attention byte.

// File: rtl/dcs_pkg.sv
// Shared constants, register selects, result codes and types for the
// disk command issue sequencer. Assumes a 16-bit command word whose
// bit layout (code, device, options) is decoded by the attachment.
package dcs_pkg;

    localparam int unsigned WORD_W    = 16;
    localparam int unsigned ATTN_W    = 5;
    localparam int unsigned DEV_W     = 3;
    localparam int unsigned CMD_W     = 5;
    localparam int unsigned OPT_W     = 8;
    localparam int unsigned STAT_W    = 2;
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned MAX_WORDS = 4;
    localparam int unsigned ARGS_W    = (MAX_WORDS - 1) * WORD_W;
    localparam int unsigned IDX_W     = $clog2(MAX_WORDS);
    localparam int unsigned LONG_BIT  = 14;

    // Status bit positions seen by the attachment contract
    localparam int unsigned STAT_BUSY = 0;
    localparam int unsigned STAT_FULL = 1;

    localparam logic [WORD_W-1:0] CTRL_OFF   = '0;
    localparam logic [WORD_W-1:0] CTRL_IRQEN = WORD_W'(1);

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_ATTN = 2'd2,
        REG_CMD  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RES_OK           = 2'd0,
        RES_BUSY_TIMEOUT = 2'd1,
        RES_CMD_TIMEOUT  = 2'd2
    } dcs_result_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_IRQ_OFF,
        S_BUSY_RD,
        S_BUSY_CHK,
        S_BUSY_GAP,
        S_ATTN,
        S_IRQ_ON,
        S_CMD_WR,
        S_FULL_RD,
        S_FULL_CHK,
        S_FULL_GAP,
        S_DONE
    } dcs_state_e;

    typedef struct packed {
        logic [ATTN_W-1:0] attn;
        logic [DEV_W-1:0]  dev;
        logic [CMD_W-1:0]  cmd;
        logic [OPT_W-1:0]  opts;
        logic              four_words;
        logic              skip_busy;
        logic              with_cmd;
        logic [ARGS_W-1:0] args;
    } dcs_req_t;

endpackage

// File: rtl/dcs_word_pack.sv
// Builds the attention byte and selects the command word for the
// current index. Purely combinational; assumes the request is held
// stable in a register by the caller for the whole sequence.
module dcs_word_pack
    import dcs_pkg::*;
(
    input  dcs_req_t          req,
    input  logic [IDX_W-1:0]  word_idx,
    output logic [7:0]        attn_byte,
    output logic [WORD_W-1:0] cmd_word
);

    logic [WORD_W-1:0] head;
    logic [WORD_W-1:0] word_tab [MAX_WORDS];

    // Pack word 0: code, device, options, length flag forced into bit 14
    always_comb begin
        head = {req.opts, req.dev, req.cmd};
        if (req.four_words) begin
            head[LONG_BIT] = 1'b1;
        end
    end

    assign word_tab[0] = head;

    // Argument words follow the head word in ascending order
    for (genvar g = 1; g < MAX_WORDS; g++) begin : g_args
        assign word_tab[g] = req.args[(g-1)*WORD_W +: WORD_W];
    end

    assign cmd_word  = word_tab[word_idx];
    assign attn_byte = {req.dev, req.attn};

endmodule

// File: rtl/dcs_poll_pacer.sv
// Counts status reads against the try limit and times the idle gap
// between reads. Assumes clr is raised once before each poll phase and
// read_pulse marks every issued status read.
module dcs_poll_pacer #(
    parameter int unsigned MAX_TRIES = 10000,
    parameter int unsigned POLL_GAP  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic read_pulse,
    input  logic gap_run,
    output logic exhausted,
    output logic gap_done
);

    localparam int unsigned TRY_W = $clog2(MAX_TRIES + 1);
    localparam int unsigned GAP_W = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;

    logic [TRY_W-1:0] tries;
    logic [GAP_W-1:0] gap_cnt;

    // Try counter: cleared per phase, bumped on each status read
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tries <= '0;
        end else if (read_pulse) begin
            tries <= tries + TRY_W'(1);
        end
    end

    // Gap counter: runs only while the sequencer waits between reads
    always_ff @(posedge clk) begin
        if (!rst_n || !gap_run || gap_done) begin
            gap_cnt <= '0;
        end else begin
            gap_cnt <= gap_cnt + GAP_W'(1);
        end
    end

    assign exhausted = (tries == TRY_W'(MAX_TRIES));
    assign gap_done  = gap_run && (gap_cnt == GAP_W'(POLL_GAP - 1));

endmodule

// File: rtl/dcs_issue_seq.sv
// Top of the disk command issue sequencer. Runs the attention handshake
// (interrupts off, busy poll, attention write, interrupts on), then
// streams two or four command words, each paced on the full flag.
// Assumes a register port with read data valid one cycle after reg_re.
module dcs_issue_seq
    import dcs_pkg::*;
#(
    parameter int unsigned MAX_TRIES = 10000,
    parameter int unsigned POLL_GAP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ATTN_W-1:0] req_attn,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [OPT_W-1:0]  req_opts,
    input  logic              req_four_words,
    input  logic              req_skip_busy,
    input  logic              req_with_cmd,
    input  logic [ARGS_W-1:0] req_args,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic              reg_re,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [STAT_W-1:0] reg_rdata,
    output logic              done,
    output logic [1:0]        done_code
);

    dcs_state_e        state, nxt;
    dcs_req_t          req_q;
    dcs_result_e       result_q;
    logic [IDX_W-1:0]  word_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [7:0]        attn_byte;
    logic [WORD_W-1:0] cmd_word;
    logic              exhausted;
    logic              gap_done;
    logic              pacer_clr;
    logic              gap_run;
    logic              accept;

    assign accept   = req_valid && (state == S_IDLE);
    assign last_idx = req_q.four_words ? IDX_W'(MAX_WORDS - 1) : IDX_W'(1);

    dcs_word_pack u_pack (
        .req       (req_q),
        .word_idx  (word_idx),
        .attn_byte (attn_byte),
        .cmd_word  (cmd_word)
    );

    assign pacer_clr = (state == S_IRQ_OFF) || (state == S_CMD_WR);
    assign gap_run   = (state == S_BUSY_GAP) || (state == S_FULL_GAP);

    dcs_poll_pacer #(
        .MAX_TRIES (MAX_TRIES),
        .POLL_GAP  (POLL_GAP)
    ) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (pacer_clr),
        .read_pulse (reg_re),
        .gap_run    (gap_run),
        .exhausted  (exhausted),
        .gap_done   (gap_done)
    );

    // Next-state logic for the attention and command streaming sequence
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (req_valid) nxt = S_IRQ_OFF;
            S_IRQ_OFF:  nxt = req_q.skip_busy ? S_ATTN : S_BUSY_RD;
            S_BUSY_RD:  nxt = S_BUSY_CHK;
            S_BUSY_CHK: begin
                if (!reg_rdata[STAT_BUSY]) nxt = S_ATTN;
                else if (exhausted)        nxt = S_DONE;
                else                       nxt = S_BUSY_GAP;
            end
            S_BUSY_GAP: if (gap_done) nxt = S_BUSY_RD;
            S_ATTN:     nxt = S_IRQ_ON;
            S_IRQ_ON:   nxt = req_q.with_cmd ? S_CMD_WR : S_DONE;
            S_CMD_WR:   nxt = S_FULL_RD;
            S_FULL_RD:  nxt = S_FULL_CHK;
            S_FULL_CHK: begin
                if (!reg_rdata[STAT_FULL]) nxt = (word_idx == last_idx) ? S_DONE : S_CMD_WR;
                else if (exhausted)        nxt = S_DONE;
                else                       nxt = S_FULL_GAP;
            end
            S_FULL_GAP: if (gap_done) nxt = S_FULL_RD;
            S_DONE:     nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Request capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.attn       <= req_attn;
            req_q.dev        <= req_dev;
            req_q.cmd        <= req_cmd;
            req_q.opts       <= req_opts;
            req_q.four_words <= req_four_words;
            req_q.skip_busy  <= req_skip_busy;
            req_q.with_cmd   <= req_with_cmd;
            req_q.args       <= req_args;
        end
    end

    // Word index: restarts per request, advances when a word is taken
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            word_idx <= '0;
        end else if (state == S_FULL_CHK && !reg_rdata[STAT_FULL] && word_idx != last_idx) begin
            word_idx <= word_idx + IDX_W'(1);
        end
    end

    // Result code: ok by default, overwritten by a timeout verdict
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            result_q <= RES_OK;
        end else if (state == S_BUSY_CHK && reg_rdata[STAT_BUSY] && exhausted) begin
            result_q <= RES_BUSY_TIMEOUT;
        end else if (state == S_FULL_CHK && reg_rdata[STAT_FULL] && exhausted) begin
            result_q <= RES_CMD_TIMEOUT;
        end
    end

    // Register port drive decoded from the current state
    always_comb begin
        reg_we    = 1'b0;
        reg_re    = 1'b0;
        reg_addr  = REG_CTRL;
        reg_wdata = '0;
        unique case (state)
            S_IRQ_OFF: begin
                reg_we    = 1'b1;
                reg_wdata = CTRL_OFF;
            end
            S_BUSY_RD, S_FULL_RD: begin
                reg_re   = 1'b1;
                reg_addr = REG_STAT;
            end
            S_ATTN: begin
                reg_we    = 1'b1;
                reg_addr  = REG_ATTN;
                reg_wdata = {8'h00, attn_byte};
            end
            S_IRQ_ON: begin
                reg_we    = 1'b1;
                reg_wdata = CTRL_IRQEN;
            end
            S_CMD_WR: begin
                reg_we    = 1'b1;
                reg_addr  = REG_CMD;
                reg_wdata = cmd_word;
            end
            default: ;
        endcase
    end

    assign req_ready = (state == S_IDLE);
    assign done      = (state == S_DONE);
    assign done_code = done ? result_q : RES_OK;

endmodule

// File: rtl/dcs_issue_seq_chk.sv
// Protocol checker for the issue sequencer, attached by bind. Observes
// the top-level ports only.
module dcs_issue_seq_chk
    import dcs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic              reg_re,
    input logic [WORD_W-1:0] reg_wdata,
    input logic              done,
    input logic [1:0]        done_code
);

    a_r1_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!reg_we && !reg_re && !done));

    a_r2_accept_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (reg_we && reg_addr == REG_CTRL && reg_wdata == CTRL_OFF));

    a_r5_attn_then_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == REG_ATTN) |=> (reg_we && reg_addr == REG_CTRL && reg_wdata == CTRL_IRQEN));

    a_r8_word_then_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == REG_CMD) |=> (reg_re && reg_addr == REG_STAT));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    a_r10_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_code != 2'd3));

    a_r11_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    a_r11_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

endmodule

bind dcs_issue_seq dcs_issue_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_wdata (reg_wdata),
    .done      (done),
    .done_code (done_code)
);

// File: tb/dcs_issue_seq_tb_top.sv
module dcs_issue_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAXT       = 6;
    localparam int GAP        = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_attn = '0;
    logic [2:0]  req_dev = '0;
    logic [4:0]  req_cmd = '0;
    logic [7:0]  req_opts = '0;
    logic        req_four_words = 1'b0;
    logic        req_skip_busy = 1'b0;
    logic        req_with_cmd = 1'b0;
    logic [47:0] req_args = '0;
    logic [1:0]  reg_addr;
    logic        reg_we;
    logic        reg_re;
    logic [15:0] reg_wdata;
    logic [1:0]  reg_rdata;
    logic        done;
    logic [1:0]  done_code;

    int checks = 0;
    int errors = 0;

    // responder configuration and observation
    logic        load = 1'b0;
    int          cfg_busy = 0;
    int          cfg_full = 0;
    int          busy_left, full_left, stat_reads, done_cnt, log_n;
    logic [1:0]  log_addr [16];
    logic [15:0] log_data [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    dcs_issue_seq #(.MAX_TRIES(MAXT), .POLL_GAP(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_attn(req_attn), .req_dev(req_dev), .req_cmd(req_cmd), .req_opts(req_opts),
        .req_four_words(req_four_words), .req_skip_busy(req_skip_busy),
        .req_with_cmd(req_with_cmd), .req_args(req_args),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .done(done), .done_code(done_code)
    );

    // Attachment register responder and write logger
    always @(posedge clk) begin
        if (load) begin
            busy_left  <= cfg_busy;
            full_left  <= 0;
            stat_reads <= 0;
            done_cnt   <= 0;
            log_n      <= 0;
            reg_rdata  <= 2'b00;
        end else begin
            if (reg_re && reg_addr == 2'd1) begin
                reg_rdata  <= {full_left > 0, busy_left > 0};
                if (busy_left > 0) busy_left <= busy_left - 1;
                if (full_left > 0) full_left <= full_left - 1;
                stat_reads <= stat_reads + 1;
            end
            if (reg_we) begin
                if (log_n < 16) begin
                    log_addr[log_n] <= reg_addr;
                    log_data[log_n] <= reg_wdata;
                end
                log_n <= log_n + 1;
                if (reg_addr == 2'd3) full_left <= cfg_full;
            end
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic run_case(input int dev, input int atype, input int cmd, input int opts,
                            input bit lng, input bit skip, input bit wc, input int k,
                            input int f, input bit poke, input logic [47:0] args);
        int          exp_len, exp_code, exp_reads, nwords, waited;
        logic [1:0]  ea [8];
        logic [15:0] ed [8];
        logic [15:0] w [4];
        nwords = lng ? 4 : 2;
        w[0] = 16'(cmd & 31) | 16'((dev & 7) << 5) | 16'((opts & 255) << 8) | (lng ? 16'h4000 : 16'h0);
        w[1] = args[15:0]; w[2] = args[31:16]; w[3] = args[47:32];
        ea[0] = 2'd0; ed[0] = 16'h0000;
        exp_reads = skip ? 0 : ((k < MAXT) ? k + 1 : MAXT);
        if (!skip && k >= MAXT) begin
            exp_len = 1; exp_code = 1;
        end else begin
            ea[1] = 2'd2; ed[1] = 16'((atype & 31) | ((dev & 7) << 5));
            ea[2] = 2'd0; ed[2] = 16'h0001;
            if (!wc) begin
                exp_len = 3; exp_code = 0;
            end else if (f >= MAXT) begin
                ea[3] = 2'd3; ed[3] = w[0];
                exp_len = 4; exp_code = 2; exp_reads += MAXT;
            end else begin
                for (int i = 0; i < nwords; i++) begin
                    ea[3+i] = 2'd3; ed[3+i] = w[i];
                end
                exp_len = 3 + nwords; exp_code = 0; exp_reads += nwords * (f + 1);
            end
        end
        @(negedge clk);
        cfg_busy = k; cfg_full = f; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        req_dev = 3'(dev); req_attn = 5'(atype); req_cmd = 5'(cmd); req_opts = 8'(opts);
        req_four_words = lng; req_skip_busy = skip; req_with_cmd = wc; req_args = args;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            // R1: a request while busy must be ignored
            req_dev = 3'(dev ^ 5); req_attn = 5'(atype ^ 9); req_skip_busy = ~skip;
            req_with_cmd = 1'b1; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        waited = 0;
        while (!done && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        chk(waited < 4000, "R10 done seen", waited, 0);
        chk(done_code == 2'(exp_code),
            exp_code == 1 ? "R4 busy timeout code" : (exp_code == 2 ? "R9 cmd timeout code" : "R6/R10 ok code"),
            done_code, exp_code);
        @(negedge clk);
        chk(!done && req_ready, "R10 single pulse then ready", {done, req_ready}, 1);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R1 R10 one done per request", done_cnt, 1);
        chk(log_n == exp_len, "R4 R8 R9 write count", log_n, exp_len);
        chk(stat_reads == exp_reads, "R3 R8 status read count", stat_reads, exp_reads);
        for (int i = 0; i < exp_len && i < log_n && i < 8; i++) begin
            chk(log_addr[i] == ea[i], i == 1 ? "R5 attn addr" : "R2 R8 write addr", log_addr[i], ea[i]);
            chk(log_data[i] == ed[i], i == 1 ? "R5 attn byte" : (i == 3 ? "R7 word0" : "R8 write data"),
                log_data[i], ed[i]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d exp %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int kv [4];
        int fv [4];
        kv = '{0, 1, MAXT - 1, MAXT};
        fv = '{0, 2, MAXT - 1, MAXT};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !reg_we && !reg_re, "R1 reset state", {req_ready, done, reg_we, reg_re}, 8);
        // Sweep devices, lengths, busy depths, full depths
        for (int dev = 0; dev < 8; dev++) begin
            for (int lng = 0; lng < 2; lng++) begin
                for (int ki = 0; ki < 4; ki++) begin
                    run_case(dev, (dev * 7 + ki * 3) % 32, (dev * 4 + ki + lng * 11) % 32,
                             (dev * 37 + ki * 53 + lng * 64) % 256, lng[0],
                             ((dev + ki) % 3) == 0, ((dev + ki) % 4) != 3,
                             kv[ki], fv[(dev + lng + ki) % 4], (dev + ki) % 2 == 1,
                             {16'(dev * 257 + 3), 16'(ki * 4099 + lng), 16'(16'hA5A5 ^ dev)});
                end
            end
        end
        // Controller reset attention on device 7 with busy held and skipped (R3, R5)
        run_case(7, 5'h1F, 0, 0, 1'b0, 1'b1, 1'b0, MAXT, 0, 1'b0, 48'h0);
        // Busy clears on the very last allowed read (R4 boundary)
        run_case(2, 3, 9, 8'hFF, 1'b1, 1'b0, 1'b1, MAXT - 1, MAXT - 1, 1'b0, 48'h1234_5678_9ABC);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule